// File: doc/BRIEF.md
# Four-Phase Handshake Bridge Sequencer

This block joins an upstream four-phase handshake (request in, acknowledge out) to a downstream four-phase handshake (request out, acknowledge in). It steps through a fixed ring of four states. In each state it waits for exactly one edge on one input. When that edge arrives, it makes exactly one change on one output and moves to the next state. The upstream request is forwarded downstream. The downstream acknowledge closes the forward phase. The upstream release is answered by withdrawing the upstream acknowledge. The downstream release restores that acknowledge, which completes the ring.

Both inputs come from outside the clock domain. Each input passes through a flop synchronizer before the block looks at it. Outputs come straight from flops and cannot glitch. The environment must hold off its next edge until the response to the previous one has appeared on the outputs.

The block also watches for protocol violations. Any input edge other than the one the current state waits for sets a protocol-error flag. The flag stays set until reset. The violating edge never moves the state.

Top module: `hs_burst_ctrl`

## Requirements
- R1: While reset is held and after it is released with both inputs low, the block waits for the upstream request to rise, with the downstream request at 0, the upstream acknowledge at 1 and the error flag at 0.
- R2: In the waiting-for-upstream-request state, a rising upstream request sets the downstream request to 1, and the block then waits for the downstream acknowledge to rise.
- R3: In that state, a rising downstream acknowledge clears the downstream request to 0, and the block then waits for the upstream request to fall.
- R4: In that state, a falling upstream request clears the upstream acknowledge to 0, and the block then waits for the downstream acknowledge to fall.
- R5: In that state, a falling downstream acknowledge sets the upstream acknowledge back to 1, and the block returns to waiting for the upstream request to rise. The ring repeats without limit.
- R6: With the default two synchronizer stages, an input change captured at clock edge n shows on the outputs just after edge n+2. The outputs hold their old values after edges n and n+1.
- R7: An input edge that the current state does not wait for sets the error flag, with the same latency as R6, and leaves both outputs and the state unchanged.
- R8: The error flag stays at 1 until reset, through further illegal edges and through later legal steps. Legal steps continue to advance the ring while the flag is set.
- R9: When the awaited edge and an edge on the other input are captured in the same cycle, the ring advances and the error flag is set in that same cycle.
- R10: No more than one output changes at any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req_i | input | 1 | Upstream request, asynchronous |
| up_ack_o | output | 1 | Upstream acknowledge, registered |
| dn_req_o | output | 1 | Downstream request, registered |
| dn_ack_i | input | 1 | Downstream acknowledge, asynchronous |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
Advancing the ring and flagging a violation can happen in the same clock cycle. This occurs when the awaited edge and a stray edge on the other input reach the end of the synchronizer together. The bench provokes this case in each of the four states by toggling both inputs at the same falling clock edge. It then expects the next state's output pattern, a set error flag and exactly one changed output. In a separate sweep, the bench injects a lone stray edge in every state and expects the outputs to stay unchanged while the flag rises.

// File: rtl/hs_burst_pkg.sv
package hs_burst_pkg;

    localparam int unsigned IN_W      = 2;
    localparam int unsigned IN_UP_REQ = 0;
    localparam int unsigned IN_DN_ACK = 1;

    typedef enum logic [1:0] {
        ST_WAIT_UREQ_HI = 2'd0,
        ST_WAIT_DACK_HI = 2'd1,
        ST_WAIT_UREQ_LO = 2'd2,
        ST_WAIT_DACK_LO = 2'd3
    } hsb_state_t;

    typedef struct packed {
        logic req_rise;
        logic req_fall;
        logic ack_rise;
        logic ack_fall;
    } hsb_edges_t;

    typedef struct packed {
        logic dn_req;
        logic up_ack;
    } hsb_outs_t;

    localparam hsb_outs_t OUTS_RESET = '{dn_req: 1'b0, up_ack: 1'b1};

    function automatic hsb_state_t hsb_next(input hsb_state_t s);
        unique case (s)
            ST_WAIT_UREQ_HI: return ST_WAIT_DACK_HI;
            ST_WAIT_DACK_HI: return ST_WAIT_UREQ_LO;
            ST_WAIT_UREQ_LO: return ST_WAIT_DACK_LO;
            default:         return ST_WAIT_UREQ_HI;
        endcase
    endfunction

    function automatic hsb_outs_t hsb_outs(input hsb_state_t s);
        hsb_outs_t o;
        o.dn_req = (s == ST_WAIT_DACK_HI);
        o.up_ack = (s != ST_WAIT_DACK_LO);
        return o;
    endfunction

    function automatic hsb_edges_t hsb_expected(input hsb_state_t s);
        hsb_edges_t m;
        m = '0;
        unique case (s)
            ST_WAIT_UREQ_HI: m.req_rise = 1'b1;
            ST_WAIT_DACK_HI: m.ack_rise = 1'b1;
            ST_WAIT_UREQ_LO: m.req_fall = 1'b1;
            default:         m.ack_fall = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/hsb_edge_det.sv
module hsb_edge_det
    import hs_burst_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] lvl,
    output hsb_edges_t      edges
);
    logic [IN_W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    always_comb begin
        edges.req_rise =  lvl[IN_UP_REQ] & ~prev[IN_UP_REQ];
        edges.req_fall = ~lvl[IN_UP_REQ] &  prev[IN_UP_REQ];
        edges.ack_rise =  lvl[IN_DN_ACK] & ~prev[IN_DN_ACK];
        edges.ack_fall = ~lvl[IN_DN_ACK] &  prev[IN_DN_ACK];
    end
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
    import hs_burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  hsb_edges_t edges,
    output hsb_outs_t  outs,
    output logic       err
);
    hsb_state_t state;
    hsb_edges_t want;
    logic       advance;
    logic       stray;

    always_comb begin
        want    = hsb_expected(state);
        advance = |(edges & want);
        stray   = |(edges & ~want);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT_UREQ_HI;
            outs  <= OUTS_RESET;
            err   <= 1'b0;
        end else begin
            if (advance) begin
                state <= hsb_next(state);
                outs  <= hsb_outs(hsb_next(state));
            end
            if (stray) err <= 1'b1;
        end
    end
endmodule

// File: rtl/hs_burst_ctrl.sv
module hs_burst_ctrl
    import hs_burst_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic up_req_i,
    output logic up_ack_o,
    output logic dn_req_o,
    input  logic dn_ack_i,
    output logic proto_err_o
);
    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] sync_q;
    logic            up_sync;
    logic            dn_sync;
    hsb_edges_t      edges;
    hsb_outs_t       outs;

    always_comb begin
        raw_in            = '0;
        raw_in[IN_UP_REQ] = up_req_i;
        raw_in[IN_DN_ACK] = dn_ack_i;
    end

    hsb_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_q)
    );

    assign up_sync = sync_q[IN_UP_REQ];
    assign dn_sync = sync_q[IN_DN_ACK];

    hsb_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (sync_q),
        .edges (edges)
    );

    hsb_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .edges (edges),
        .outs  (outs),
        .err   (proto_err_o)
    );

    assign dn_req_o = outs.dn_req;
    assign up_ack_o = outs.up_ack;
endmodule

// File: rtl/hs_burst_ctrl_chk.sv
module hs_burst_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic up_sync,
    input logic dn_sync,
    input logic up_ack_o,
    input logic dn_req_o,
    input logic proto_err_o
);
    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (!dn_req_o && up_ack_o && !proto_err_o)); // R1

    AST_DNREQ_RISE_ON_UREQ_HI: assert property (@(posedge clk) disable iff (rst)
        $rose(dn_req_o) |-> $past(up_sync)); // R2

    AST_DNREQ_FALL_ON_DACK_HI: assert property (@(posedge clk) disable iff (rst)
        $fell(dn_req_o) |-> $past(dn_sync)); // R3

    AST_UACK_FALL_ON_UREQ_LO: assert property (@(posedge clk) disable iff (rst)
        $fell(up_ack_o) |-> !$past(up_sync)); // R4

    AST_UACK_RISE_ON_DACK_LO: assert property (@(posedge clk) disable iff (rst)
        $rose(up_ack_o) |-> !$past(dn_sync)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |=> proto_err_o); // R8

    AST_ONE_OUTPUT_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones({dn_req_o != $past(dn_req_o), up_ack_o != $past(up_ack_o)}) <= 1); // R10
endmodule

bind hs_burst_ctrl hs_burst_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .up_sync     (up_sync),
    .dn_sync     (dn_sync),
    .up_ack_o    (up_ack_o),
    .dn_req_o    (dn_req_o),
    .proto_err_o (proto_err_o)
);

// File: tb/hs_burst_ctrl_bench.sv
module hs_burst_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_req = 1'b0;
    logic dn_ack = 1'b0;
    logic up_ack;
    logic dn_req;
    logic perr;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hs_burst_ctrl u_hs_burst_ctrl (
        .clk         (clk),
        .rst         (rst),
        .up_req_i    (up_req),
        .up_ack_o    (up_ack),
        .dn_req_o    (dn_req),
        .dn_ack_i    (dn_ack),
        .proto_err_o (perr)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_dn(input int idx);
        return (idx == 1);
    endfunction

    function automatic logic exp_ack(input int idx);
        return (idx != 3);
    endfunction

    function automatic string step_tag(input int idx);
        case (idx)
            0: return "R5";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check_outs(input string tag, input int idx, input logic e_err);
        check({tag, " dn_req"}, dn_req, exp_dn(idx));
        check({tag, " up_ack"}, up_ack, exp_ack(idx));
        check({tag, " err"}, perr, e_err);
    endtask

    // even states watch the upstream request, odd ones the downstream acknowledge
    task automatic apply(input int idx, input bit legal, input bit other);
        if (idx % 2 == 0) begin
            if (legal) up_req = (idx == 0);
            if (other) dn_ack = ~dn_ack;
        end else begin
            if (legal) dn_ack = (idx == 1);
            if (other) up_req = ~up_req;
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        up_req = 1'b0;
        dn_ack = 1'b0;
        wait_n(3);
        rst = 1'b0;
        wait_n(2);
    endtask

    task automatic advance_to(input int st);
        for (int k = 0; k < st; k++) begin
            apply(k, 1'b1, 1'b0);
            wait_n(4);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired got=running exp=done");
        summary();
    end

    initial begin
        // R1: reset state
        wait_n(1);
        check_outs("R1 during reset", 0, 1'b0);
        do_reset();
        check_outs("R1 after reset", 0, 1'b0);

        // three full rings, latency examined on the first step
        begin
            int idx = 0;
            for (int c = 0; c < 3; c++) begin
                for (int s = 0; s < 4; s++) begin
                    apply(idx, 1'b1, 1'b0);
                    if (c == 0 && s == 0) begin
                        wait_n(2);
                        check_outs("R6 hold edge n+1", 0, 1'b0);
                        wait_n(1);
                        check_outs("R6 change edge n+2", 1, 1'b0);
                        wait_n(1);
                    end else begin
                        wait_n(4);
                        check_outs(step_tag((idx + 1) % 4), (idx + 1) % 4, 1'b0);
                    end
                    idx = (idx + 1) % 4;
                end
            end
        end

        // lone stray edge in every state, then stickiness
        for (int st = 0; st < 4; st++) begin
            do_reset();
            advance_to(st);
            check_outs("R7 before stray", st, 1'b0);
            apply(st, 1'b0, 1'b1);
            wait_n(2);
            check("R7 err latency", perr, 1'b0);
            wait_n(2);
            check_outs("R7 stray ignored", st, 1'b1);
            apply(st, 1'b0, 1'b1);
            wait_n(4);
            check_outs("R8 second stray", st, 1'b1);
            apply(st, 1'b1, 1'b0);
            wait_n(4);
            check_outs("R8 legal after error", (st + 1) % 4, 1'b1);
        end

        // awaited edge and stray edge captured together
        for (int st = 0; st < 4; st++) begin
            logic pd;
            logic pa;
            int changes;
            do_reset();
            advance_to(st);
            pd = dn_req;
            pa = up_ack;
            apply(st, 1'b1, 1'b1);
            wait_n(4);
            check_outs("R9 coincident", (st + 1) % 4, 1'b1);
            changes = int'(pd != dn_req) + int'(pa != up_ack);
            check("R10 single output change", changes == 1, 1'b1);
        end

        summary();
    end
endmodule